// File: doc/BRIEF.md
# Addressed Serial Configuration Loader

This block is the three-wire programming port of a dual frequency synthesizer. A host shifts a 22-bit word into the block over a serial clock and data line, most significant bit first, and then raises a load strobe. On that rising edge the two lowest bits of the word act as an address. They steer the remaining 20 bits into one of four holding registers: the auxiliary or main reference divider, or the auxiliary or main feedback divider.

The three serial inputs are asynchronous to the system clock. Each is passed through a synchroniser and then edge-detected in the system clock domain. The holding registers drive decoded fields directly:
- each reference register gives a 15-bit divide ratio and five mode bits;
- each feedback register gives a 5-bit swallow count, a 13-bit program count, a prescaler select bit and a power-down bit.

A reference ratio below two is still stored, but it raises a per-register flag until a legal ratio replaces it.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each rising edge of the synchronised serial clock while load enable is low, the shift register moves left one place and takes the data bit into bit 0. After 22 edges the first bit sent sits at bit 21.
- R2: Rising edges of the serial clock while load enable is high do not alter the shift register. A later load therefore stores the word shifted in before load enable rose.
- R3: Each rising edge of load enable writes the upper 20 bits of the shift register into exactly one holding register. The address in bits [1:0] selects it: 00 auxiliary reference, 10 main reference, 01 auxiliary feedback, 11 main feedback.
- R4: Between loads every holding register and every flag keeps its value, and a load leaves the three unaddressed registers unchanged.
- R5: In a reference word, bits [16:2] give the divide ratio, with bit 2 as its least significant bit, and bits [21:17] give the five mode bits.
- R6: In a feedback word, bits [6:2] give the swallow count, bits [19:7] the program count, bit 20 the prescaler select and bit 21 the power-down bit (1 means powered down).
- R7: A reference ratio of 0 or 1 is stored as written and sets that register's invalid flag. A later load of a ratio from 2 to 32767 into the same register clears the flag.
- R8: Synchronous reset sets every ratio, mode, count and prescaler field to zero and clears both invalid flags. Both power-down bits reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| load_en | input | 1 | Load strobe; rising edge latches the word |
| aux_ref_ratio | output | 15 | Auxiliary reference divide ratio |
| aux_ref_mode | output | 5 | Auxiliary reference mode bits |
| aux_ref_bad | output | 1 | Auxiliary reference ratio below 2 |
| main_ref_ratio | output | 15 | Main reference divide ratio |
| main_ref_mode | output | 5 | Main reference mode bits |
| main_ref_bad | output | 1 | Main reference ratio below 2 |
| aux_fb_swallow | output | 5 | Auxiliary swallow count |
| aux_fb_program | output | 13 | Auxiliary program count |
| aux_fb_presc | output | 1 | Auxiliary prescaler select |
| aux_fb_pwrdn | output | 1 | Auxiliary power-down, 1 = down |
| main_fb_swallow | output | 5 | Main swallow count |
| main_fb_program | output | 13 | Main program count |
| main_fb_presc | output | 1 | Main prescaler select |
| main_fb_pwrdn | output | 1 | Main power-down, 1 = down |

## Verification
The bench walks all four addresses with patterns at the extremes of each field. Maximum ratio and all-ones counts show an off-by-one slice, because a stray bit lands in the neighbouring field. Both addresses with mixed bits, 01 and 10, are used, so a swapped address decode writes the wrong register and the untouched registers visibly change. A second test toggles the serial clock while load enable is high and then reloads. A design that keeps shifting at that time stores a corrupted word. Ratios 1 and 0 followed by ratio 2 probe the invalid flag at both sides of its threshold: a wrong compare would miss the flag or fail to clear it.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SR_W     = 22;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = SR_W - ADDR_W;
  localparam int RATIO_W  = 15;
  localparam int MODE_W   = DATA_W - RATIO_W;
  localparam int SWAL_W   = 5;
  localparam int PROG_W   = 13;
  localparam int RATIO_MIN = 2;

  localparam logic [ADDR_W-1:0] A_AUX_REF  = 2'b00;
  localparam logic [ADDR_W-1:0] A_AUX_FB   = 2'b01;
  localparam logic [ADDR_W-1:0] A_MAIN_REF = 2'b10;
  localparam logic [ADDR_W-1:0] A_MAIN_FB  = 2'b11;

  typedef struct packed {
    logic              pwrdn;
    logic              presc;
    logic [PROG_W-1:0] prog;
    logic [SWAL_W-1:0] swal;
  } fb_word_t;

  typedef struct packed {
    logic [MODE_W-1:0]  mode;
    logic [RATIO_W-1:0] ratio;
  } ref_word_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/scl_ref_reg.sv
module scl_ref_reg
  import scl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [DATA_W-1:0]  data,
  output logic [RATIO_W-1:0] ratio,
  output logic [MODE_W-1:0]  mode,
  output logic               bad
);
  localparam logic [RATIO_W-1:0] MIN_V = RATIO_W'(RATIO_MIN);
  ref_word_t w;
  assign w = ref_word_t'(data);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio <= '0;
      mode  <= '0;
      bad   <= 1'b0;
    end else if (we) begin
      ratio <= w.ratio;
      mode  <= w.mode;
      bad   <= (w.ratio < MIN_V);
    end
  end
endmodule

// File: rtl/scl_fb_reg.sv
module scl_fb_reg
  import scl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] data,
  output logic [SWAL_W-1:0] swal,
  output logic [PROG_W-1:0] prog,
  output logic              presc,
  output logic              pwrdn
);
  fb_word_t w;
  assign w = fb_word_t'(data);

  always_ff @(posedge clk) begin
    if (rst) begin
      swal  <= '0;
      prog  <= '0;
      presc <= 1'b0;
      pwrdn <= 1'b1;
    end else if (we) begin
      swal  <= w.swal;
      prog  <= w.prog;
      presc <= w.presc;
      pwrdn <= w.pwrdn;
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import scl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               load_en,
  output logic [RATIO_W-1:0] aux_ref_ratio,
  output logic [MODE_W-1:0]  aux_ref_mode,
  output logic               aux_ref_bad,
  output logic [RATIO_W-1:0] main_ref_ratio,
  output logic [MODE_W-1:0]  main_ref_mode,
  output logic               main_ref_bad,
  output logic [SWAL_W-1:0]  aux_fb_swallow,
  output logic [PROG_W-1:0]  aux_fb_program,
  output logic               aux_fb_presc,
  output logic               aux_fb_pwrdn,
  output logic [SWAL_W-1:0]  main_fb_swallow,
  output logic [PROG_W-1:0]  main_fb_program,
  output logic               main_fb_presc,
  output logic               main_fb_pwrdn
);
  localparam int UNITS = 2; // index 0 = auxiliary, 1 = main

  logic [2:0] lvl;           // {load_en, ser_clk, ser_data} synchronised
  logic       sclk_d, le_d;
  logic       sclk_rise, load_pulse;
  logic [SR_W-1:0]   sr_word;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] payload;

  scl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({load_en, ser_clk, ser_data}),
    .sync_out(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= lvl[1];
      le_d   <= lvl[2];
    end
  end

  assign sclk_rise  = lvl[1] & ~sclk_d & ~lvl[2];
  assign load_pulse = lvl[2] & ~le_d;

  scl_shifter #(.W(SR_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .bit_in(lvl[0]), .word(sr_word)
  );

  assign addr    = sr_word[ADDR_W-1:0];
  assign payload = sr_word[SR_W-1:ADDR_W];

  logic [RATIO_W-1:0] r_ratio [UNITS];
  logic [MODE_W-1:0]  r_mode  [UNITS];
  logic               r_bad   [UNITS];
  logic [SWAL_W-1:0]  f_swal  [UNITS];
  logic [PROG_W-1:0]  f_prog  [UNITS];
  logic               f_presc [UNITS];
  logic               f_pwrdn [UNITS];

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    localparam logic [ADDR_W-1:0] REF_A = (g == 0) ? A_AUX_REF : A_MAIN_REF;
    localparam logic [ADDR_W-1:0] FB_A  = (g == 0) ? A_AUX_FB  : A_MAIN_FB;
    logic ref_we, fb_we;
    assign ref_we = load_pulse && (addr == REF_A);
    assign fb_we  = load_pulse && (addr == FB_A);

    scl_ref_reg u_ref (
      .clk(clk), .rst(rst), .we(ref_we), .data(payload),
      .ratio(r_ratio[g]), .mode(r_mode[g]), .bad(r_bad[g])
    );
    scl_fb_reg u_fb (
      .clk(clk), .rst(rst), .we(fb_we), .data(payload),
      .swal(f_swal[g]), .prog(f_prog[g]), .presc(f_presc[g]), .pwrdn(f_pwrdn[g])
    );
  end

  assign aux_ref_ratio   = r_ratio[0];
  assign aux_ref_mode    = r_mode[0];
  assign aux_ref_bad     = r_bad[0];
  assign main_ref_ratio  = r_ratio[1];
  assign main_ref_mode   = r_mode[1];
  assign main_ref_bad    = r_bad[1];
  assign aux_fb_swallow  = f_swal[0];
  assign aux_fb_program  = f_prog[0];
  assign aux_fb_presc    = f_presc[0];
  assign aux_fb_pwrdn    = f_pwrdn[0];
  assign main_fb_swallow = f_swal[1];
  assign main_fb_program = f_prog[1];
  assign main_fb_presc   = f_presc[1];
  assign main_fb_pwrdn   = f_pwrdn[1];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import scl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               load_pulse,
  input logic [RATIO_W-1:0] aux_ref_ratio,
  input logic [MODE_W-1:0]  aux_ref_mode,
  input logic               aux_ref_bad,
  input logic [RATIO_W-1:0] main_ref_ratio,
  input logic [MODE_W-1:0]  main_ref_mode,
  input logic               main_ref_bad,
  input logic [DATA_W-1:0]  aux_fb_all,
  input logic [DATA_W-1:0]  main_fb_all
);
  logic [RATIO_W+MODE_W:0] aux_ref_all, main_ref_all;
  assign aux_ref_all  = {aux_ref_bad, aux_ref_mode, aux_ref_ratio};
  assign main_ref_all = {main_ref_bad, main_ref_mode, main_ref_ratio};

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load_pulse |=> ($stable(aux_ref_all) && $stable(main_ref_all)
                     && $stable(aux_fb_all) && $stable(main_fb_all)));

  p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> ($countones({!$stable(aux_ref_all), !$stable(main_ref_all),
                                !$stable(aux_fb_all), !$stable(main_fb_all)}) <= 1));

  p_aux_bad_r7: assert property (@(posedge clk) disable iff (rst)
    aux_ref_bad |-> (aux_ref_ratio < RATIO_W'(RATIO_MIN)));

  p_main_bad_r7: assert property (@(posedge clk) disable iff (rst)
    main_ref_bad |-> (main_ref_ratio < RATIO_W'(RATIO_MIN)));

  p_legal_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ((aux_ref_ratio >= RATIO_W'(RATIO_MIN)) |-> !aux_ref_bad));

  p_reset_pwrdn_r8: assert property (@(posedge clk)
    $past(rst) |-> (aux_fb_all[DATA_W-1] && main_fb_all[DATA_W-1]));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk(clk), .rst(rst), .load_pulse(load_pulse),
  .aux_ref_ratio(aux_ref_ratio), .aux_ref_mode(aux_ref_mode), .aux_ref_bad(aux_ref_bad),
  .main_ref_ratio(main_ref_ratio), .main_ref_mode(main_ref_mode), .main_ref_bad(main_ref_bad),
  .aux_fb_all({aux_fb_pwrdn, aux_fb_presc, aux_fb_program, aux_fb_swallow}),
  .main_fb_all({main_fb_pwrdn, main_fb_presc, main_fb_program, main_fb_swallow})
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, load_en = 1'b0;
  logic [14:0] aux_ref_ratio, main_ref_ratio;
  logic [4:0]  aux_ref_mode, main_ref_mode;
  logic        aux_ref_bad, main_ref_bad;
  logic [4:0]  aux_fb_swallow, main_fb_swallow;
  logic [12:0] aux_fb_program, main_fb_program;
  logic        aux_fb_presc, main_fb_presc, aux_fb_pwrdn, main_fb_pwrdn;

  int errors = 0, checks = 0;
  logic [21:0] exp_q[$];
  string       tag_q[$];
  event        loaded;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader uut (.*);

  // Bench-side model of the four holding registers
  logic [20:0] m_ref [2];  // {bad, mode, ratio}
  logic [19:0] m_fb  [2];  // {pwrdn, presc, prog, swal}

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] ref_word(logic [4:0] mode, logic [14:0] ratio, logic [1:0] a);
    return {mode, ratio, a};
  endfunction
  function automatic logic [21:0] fb_word(logic pd, logic ps, logic [12:0] p, logic [4:0] s, logic [1:0] a);
    return {pd, ps, p, s, a};
  endfunction

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic shift_word(logic [21:0] w);
    for (int i = 21; i >= 0; i--) begin
      ser_data = w[i];
      ticks(4); ser_clk = 1'b1;
      ticks(4); ser_clk = 1'b0;
    end
  endtask

  // Raise load enable, optionally toggle the serial clock while it is high
  task automatic load(logic [21:0] w, string tag, int toggles_high);
    load_en = 1'b1;
    exp_q.push_back(w);
    tag_q.push_back(tag);
    -> loaded;
    ticks(12);
    for (int i = 0; i < toggles_high; i++) begin
      ser_data = 1'b1;
      ticks(4); ser_clk = 1'b1;
      ticks(4); ser_clk = 1'b0;
    end
    load_en = 1'b0;
    ticks(6);
  endtask

  task automatic send(logic [21:0] w, string tag);
    shift_word(w);
    load(w, tag, 0);
  endtask

  // Monitor: pop expected word, update model, compare all outputs
  initial begin
    forever begin
      @(loaded);
      ticks(8);
      @(negedge clk);
      begin
        logic [21:0] w;
        string t;
        int u;
        w = exp_q.pop_front();
        t = tag_q.pop_front();
        u = (w[1:0] == 2'b10 || w[1:0] == 2'b11) ? 1 : 0;
        if (w[1:0] == 2'b00 || w[1:0] == 2'b10)
          m_ref[u] = {(w[16:2] < 15'd2), w[21:17], w[16:2]};
        else
          m_fb[u] = w[21:2];
        check({t, " R3 aux ref"}, 64'({aux_ref_bad, aux_ref_mode, aux_ref_ratio}), 64'(m_ref[0]));
        check({t, " R3 main ref"}, 64'({main_ref_bad, main_ref_mode, main_ref_ratio}), 64'(m_ref[1]));
        check({t, " R4 aux fb"}, 64'({aux_fb_pwrdn, aux_fb_presc, aux_fb_program, aux_fb_swallow}), 64'(m_fb[0]));
        check({t, " R4 main fb"}, 64'({main_fb_pwrdn, main_fb_presc, main_fb_program, main_fb_swallow}), 64'(m_fb[1]));
      end
    end
  end

  initial begin
    m_ref[0] = '0; m_ref[1] = '0;
    m_fb[0] = {1'b1, 19'b0}; m_fb[1] = {1'b1, 19'b0};
    ticks(4);
    rst = 1'b0;
    @(negedge clk);
    check("R8 ref reset", 64'({aux_ref_bad, aux_ref_mode, aux_ref_ratio, main_ref_bad, main_ref_mode, main_ref_ratio}), 64'(0));
    check("R8 fb reset", 64'({aux_fb_pwrdn, aux_fb_presc, aux_fb_program, aux_fb_swallow,
                              main_fb_pwrdn, main_fb_presc, main_fb_program, main_fb_swallow}),
          64'({1'b1, 19'b0, 1'b1, 19'b0}));

    send(ref_word(5'h15, 15'd1000, 2'b00), "R1 R5 aux ref");
    send(ref_word(5'h00, 15'd32767, 2'b10), "R5 main ref max");
    send(fb_word(1'b0, 1'b1, 13'd4095, 5'd17, 2'b01), "R6 aux fb");
    send(fb_word(1'b0, 1'b0, 13'd8191, 5'd31, 2'b11), "R6 main fb max");
    send(ref_word(5'h1f, 15'd1, 2'b00), "R7 aux ratio 1");
    send(ref_word(5'h0a, 15'd0, 2'b10), "R7 main ratio 0");
    send(ref_word(5'h03, 15'd2, 2'b00), "R7 aux ratio 2 clears");
    send(fb_word(1'b1, 1'b0, 13'h0aaa, 5'h0a, 2'b01), "R6 aux fb pwrdn");

    // R2: shifting while load enable is high must not disturb the word
    shift_word(fb_word(1'b0, 1'b1, 13'h1555, 5'h15, 2'b11));
    load(fb_word(1'b0, 1'b1, 13'h1555, 5'h15, 2'b11), "R2 first load", 5);
    load(fb_word(1'b0, 1'b1, 13'h1555, 5'h15, 2'b11), "R2 reload", 0);

    ticks(20);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        ticks(150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule